// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the raster timing for a TFT panel: horizontal sync, vertical sync, a data-enable strobe, the current pixel column and line, and a one-cycle pulse when vertical sync begins. The pulse tells the address latch logic elsewhere that the next frame has started. The generator is set up through a write-only register port with four 32-bit words: a horizontal timing word, a vertical timing word, a polarity word and a control word. The counters advance only on clocks where the pixel-clock enable input is high. The system clock keeps running throughout.

The raster line runs through these regions in order: active pixels, front porch, sync, back porch. The frame runs through the same four regions, counted in lines. The active line width is coded in 16-pixel steps. The horizontal porch and sync fields, and the vertical sync field, hold their length minus one. The vertical porch fields hold the true line count, and zero is allowed. New timing words are held in a pending copy. They take effect at the next frame boundary, or at once while the generator is disabled.

Top module: `raster_timing_gen`

## Requirements
- R1: Horizontal word (address 0): width code in bits [7:2], sync length minus one in [15:8], front porch minus one in [23:16], back porch minus one in [31:24]. Active pixels are (code+1)*16 and the line lasts active+front+sync+back+3 counted pixels.
- R2: Horizontal sync is active for (sync field + 1) pixels. It starts at column active + front porch field + 1 and never overlaps data-enable.
- R3: Vertical word (address 1): lines minus one in bits [9:0], sync length minus one in [15:10], front porch in [23:16], back porch in [31:24], both porches as true counts including zero. The frame lasts lines+front+sync+back+2 lines. Vertical sync covers whole lines starting at line (lines field + 1 + front porch).
- R4: Data-enable is high only when the controller is enabled, the column is below the active width and the line is below the active line count.
- R5: Position counters step only on clocks with the pixel-clock enable high. The column wraps to 0 after the last pixel of a line, and the line counter steps at that wrap.
- R6: Polarity word (address 2): bit 0 inverts vertical sync, bit 1 inverts horizontal sync, bit 2 inverts the pixel clock output (pixel clock out = pixel clock in XOR bit 2). Polarity takes effect on the clock after the write.
- R7: Control word (address 3): bit 0 enables timing and bit 1 drives the panel power output, each on its own. While bit 0 is clear, the counters are held at zero and all sync and data-enable outputs sit at their inactive levels. The clock after reset shows the same idle state with normal polarity and power off.
- R8: A timing word written while enabled leaves the current frame's timing unchanged. It applies from the first line of the next frame.
- R9: The frame-start output is a single-clock pulse, raised on the clock in which the line counter enters the vertical sync region.
- R10: The column and line outputs report the counter values that the sync and data-enable outputs are decoded from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_ce | input | 1 | Pixel-clock enable; counters step on clocks where it is high |
| pclk_i | input | 1 | Raw pixel clock level to be passed through polarity control |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 horizontal, 1 vertical, 2 polarity, 3 control) |
| wr_data | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data-enable for the active region |
| pclk_o | output | 1 | Pixel clock after polarity |
| frame_start_o | output | 1 | One-clock pulse at vertical sync entry |
| panel_pwr_o | output | 1 | Panel power control |
| pix_x_o | output | 11 | Current column |
| pix_y_o | output | 11 | Current line |

## Verification
On every clock, the embedded assertions check these properties: the counters hold when there is no step, a counter wraps to zero after its last position, the counters are cleared while disabled, the active timing stays fixed between frame boundaries, horizontal sync is kept apart from data-enable, and frame-start is a single pulse inside vertical sync. The exact region boundaries are not covered by assertions and only the bench scenarios can show them. These include the minus-one and true-count field encodings, the 16-pixel width scaling, zero vertical porches, polarity inversion, power control apart from enable, and the deferral of a mid-frame write. The bench runs a cycle-by-cycle arithmetic model against the design. It sweeps porch and sync settings and also runs with a sparse pixel enable.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

   // Register select codes on the write port
   typedef enum logic [1:0] {
      RA_HTIM = 2'd0,
      RA_VTIM = 2'd1,
      RA_POL  = 2'd2,
      RA_CTRL = 2'd3
   } rtg_reg_e;

   // Polarity word, bit 0 = vsync, bit 1 = hsync, bit 2 = pixel clock
   typedef struct packed {
      logic pclk;
      logic hs;
      logic vs;
   } rtg_pol_t;

   // Control word, bit 0 = timing enable, bit 1 = panel power
   typedef struct packed {
      logic pwr;
      logic en;
   } rtg_ctrl_t;

   // Field positions inside the timing words
   localparam int HT_PPL_LSB = 2;
   localparam int HT_HSW_LSB = 8;
   localparam int HT_HFP_LSB = 16;
   localparam int HT_HBP_LSB = 24;
   localparam int VT_LPP_LSB = 0;
   localparam int VT_VSW_LSB = 10;
   localparam int VT_VFP_LSB = 16;
   localparam int VT_VBP_LSB = 24;

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
   import rtg_pkg::*;
#(
   parameter bit SHADOW = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_addr,
   input  logic [31:0] wr_data,
   input  logic        load,
   output logic [31:0] hword,
   output logic [31:0] vword,
   output rtg_pol_t    pol,
   output rtg_ctrl_t   ctrl
);

   logic [31:0] hpend;
   logic [31:0] vpend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hpend <= '0;
         vpend <= '0;
         pol   <= '0;
         ctrl  <= '0;
      end else if (wr_en) begin
         unique case (rtg_reg_e'(wr_addr))
            RA_HTIM: hpend <= wr_data;
            RA_VTIM: vpend <= wr_data;
            RA_POL:  pol   <= rtg_pol_t'(wr_data[2:0]);
            RA_CTRL: ctrl  <= rtg_ctrl_t'(wr_data[1:0]);
         endcase
      end
   end

   generate
      if (SHADOW) begin : g_shadow
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hword <= '0;
               vword <= '0;
            end else if (load) begin
               hword <= hpend;
               vword <= vpend;
            end
         end

         // R8: live timing only moves at a frame boundary or while idle
         a_r8_timing_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            !load |=> ($stable(hword) && $stable(vword)));
      end else begin : g_direct
         logic unused_load;
         assign unused_load = load;
         assign hword = hpend;
         assign vword = vpend;
      end
   endgenerate

endmodule

// File: rtl/rtg_axis.sv
module rtg_axis #(
   parameter int CW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   input  logic [CW-1:0] len_act,
   input  logic [CW-1:0] len_fp,
   input  logic [CW-1:0] len_sync,
   input  logic [CW-1:0] len_bp,
   output logic [CW-1:0] pos,
   output logic          last,
   output logic          in_act,
   output logic          in_sync,
   output logic          sync_entry
);

   logic [CW-1:0] sync_beg;
   logic [CW-1:0] sync_end;
   logic [CW-1:0] total;

   assign sync_beg = len_act + len_fp;
   assign sync_end = sync_beg + len_sync;
   assign total    = sync_end + len_bp;

   assign last       = (pos == total - CW'(1));
   assign in_act     = (pos < len_act);
   assign in_sync    = (pos >= sync_beg) && (pos < sync_end);
   assign sync_entry = step && (pos == sync_beg - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pos <= '0;
      else if (clr)    pos <= '0;
      else if (step)   pos <= last ? '0 : pos + CW'(1);
   end

   // R5: no step, no movement
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clr) |=> $stable(pos));
   // R5: wrap after the final position
   a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last) |=> (pos == '0));
   // R7: cleared while idle
   a_r7_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pos == '0));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import rtg_pkg::*;
#(
   parameter int PPL_W  = 6,
   parameter int HSW_W  = 8,
   parameter int HFP_W  = 8,
   parameter int HBP_W  = 8,
   parameter int LPP_W  = 10,
   parameter int VSW_W  = 6,
   parameter int VFP_W  = 8,
   parameter int VBP_W  = 8,
   parameter bit SHADOW = 1'b1,
   localparam int HCW = $clog2((2**PPL_W)*16 + 2**HSW_W + 2**HFP_W + 2**HBP_W + 1),
   localparam int VCW = $clog2(2**LPP_W + 2**VSW_W + 2**VFP_W + 2**VBP_W + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pix_ce,
   input  logic           pclk_i,
   input  logic           wr_en,
   input  logic [1:0]     wr_addr,
   input  logic [31:0]    wr_data,
   output logic           hsync_o,
   output logic           vsync_o,
   output logic           de_o,
   output logic           pclk_o,
   output logic           frame_start_o,
   output logic           panel_pwr_o,
   output logic [HCW-1:0] pix_x_o,
   output logic [VCW-1:0] pix_y_o
);

   // Each field must fit inside its slot of the 32-bit timing words
   generate
      if (PPL_W < 1 || PPL_W > 6) begin : g_bad_ppl
         $error("PPL_W must be 1..6");
      end
      if (HSW_W < 1 || HSW_W > 8 || HFP_W < 1 || HFP_W > 8 || HBP_W < 1 || HBP_W > 8) begin : g_bad_h
         $error("horizontal field widths must be 1..8");
      end
      if (LPP_W < 1 || LPP_W > 10 || VSW_W < 1 || VSW_W > 6) begin : g_bad_v
         $error("LPP_W must be 1..10 and VSW_W 1..6");
      end
      if (VFP_W < 1 || VFP_W > 8 || VBP_W < 1 || VBP_W > 8) begin : g_bad_vp
         $error("vertical porch widths must be 1..8");
      end
   endgenerate

   logic [31:0] hword;
   logic [31:0] vword;
   rtg_pol_t    pol;
   rtg_ctrl_t   ctrl;
   logic        load;
   logic        en;

   rtg_regs #(.SHADOW(SHADOW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .load    (load),
      .hword   (hword),
      .vword   (vword),
      .pol     (pol),
      .ctrl    (ctrl)
   );

   assign en = ctrl.en;

   // Field decode: horizontal fields all minus one, width in 16-pixel units
   logic [PPL_W-1:0] f_ppl;
   logic [HSW_W-1:0] f_hsw;
   logic [HFP_W-1:0] f_hfp;
   logic [HBP_W-1:0] f_hbp;
   logic [LPP_W-1:0] f_lpp;
   logic [VSW_W-1:0] f_vsw;
   logic [VFP_W-1:0] f_vfp;
   logic [VBP_W-1:0] f_vbp;

   assign f_ppl = hword[HT_PPL_LSB +: PPL_W];
   assign f_hsw = hword[HT_HSW_LSB +: HSW_W];
   assign f_hfp = hword[HT_HFP_LSB +: HFP_W];
   assign f_hbp = hword[HT_HBP_LSB +: HBP_W];
   assign f_lpp = vword[VT_LPP_LSB +: LPP_W];
   assign f_vsw = vword[VT_VSW_LSB +: VSW_W];
   assign f_vfp = vword[VT_VFP_LSB +: VFP_W];
   assign f_vbp = vword[VT_VBP_LSB +: VBP_W];

   logic unused_bits;
   assign unused_bits = ^hword[1:0];

   logic [HCW-1:0] h_act, h_fp, h_sy, h_bp;
   logic [VCW-1:0] v_act, v_fp, v_sy, v_bp;

   assign h_act = (HCW'(f_ppl) + HCW'(1)) << 4;
   assign h_fp  = HCW'(f_hfp) + HCW'(1);
   assign h_sy  = HCW'(f_hsw) + HCW'(1);
   assign h_bp  = HCW'(f_hbp) + HCW'(1);
   // Vertical porches are true counts; lines and sync are minus one
   assign v_act = VCW'(f_lpp) + VCW'(1);
   assign v_fp  = VCW'(f_vfp);
   assign v_sy  = VCW'(f_vsw) + VCW'(1);
   assign v_bp  = VCW'(f_vbp);

   logic           h_step, v_step;
   logic [HCW-1:0] h_pos;
   logic [VCW-1:0] v_pos;
   logic           h_last, h_in_act, h_in_sync, h_entry;
   logic           v_last, v_in_act, v_in_sync, v_entry;

   assign h_step = en && pix_ce;
   assign v_step = h_step && h_last;

   rtg_axis #(.CW(HCW)) u_haxis (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (!en),
      .step       (h_step),
      .len_act    (h_act),
      .len_fp     (h_fp),
      .len_sync   (h_sy),
      .len_bp     (h_bp),
      .pos        (h_pos),
      .last       (h_last),
      .in_act     (h_in_act),
      .in_sync    (h_in_sync),
      .sync_entry (h_entry)
   );

   rtg_axis #(.CW(VCW)) u_vaxis (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (!en),
      .step       (v_step),
      .len_act    (v_act),
      .len_fp     (v_fp),
      .len_sync   (v_sy),
      .len_bp     (v_bp),
      .pos        (v_pos),
      .last       (v_last),
      .in_act     (v_in_act),
      .in_sync    (v_in_sync),
      .sync_entry (v_entry)
   );

   logic unused_hentry;
   assign unused_hentry = h_entry;

   // Pending timing becomes live at a frame wrap, or continuously while idle
   assign load = !en || (v_step && v_last);

   logic fs_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fs_q <= 1'b0;
      else        fs_q <= en && v_entry;
   end

   logic hs_raw, vs_raw;
   assign hs_raw = en && h_in_sync;
   assign vs_raw = en && v_in_sync;

   assign de_o          = en && h_in_act && v_in_act;
   assign hsync_o       = hs_raw ^ pol.hs;
   assign vsync_o       = vs_raw ^ pol.vs;
   assign pclk_o        = pclk_i ^ pol.pclk;
   assign frame_start_o = fs_q;
   assign panel_pwr_o   = ctrl.pwr;
   assign pix_x_o       = h_pos;
   assign pix_y_o       = v_pos;

   // R9: frame-start never lasts two clocks
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fs_q |=> !fs_q);
   // R9: frame-start coincides with vertical sync region
   a_r9_inside_vsync: assert property (@(posedge clk) disable iff (!rst_n)
      fs_q |-> v_in_sync);
   // R2: horizontal sync lies in the blanking interval
   a_r2_hsync_blank: assert property (@(posedge clk) disable iff (!rst_n)
      hs_raw |-> !de_o);
   // R7: counters cleared one clock after the controller is idle
   a_r7_idle_origin: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (h_pos == '0 && v_pos == '0));

endmodule

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_ce = 1'b0;
   logic        pclk_i = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        hsync_o, vsync_o, de_o, pclk_o, frame_start_o, panel_pwr_o;
   logic [10:0] pix_x_o;
   logic [10:0] pix_y_o;

   raster_timing_gen u0 (
      .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .pclk_i(pclk_i),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pclk_o(pclk_o),
      .frame_start_o(frame_start_o), .panel_pwr_o(panel_pwr_o),
      .pix_x_o(pix_x_o), .pix_y_o(pix_y_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;

   // Arithmetic model state
   int m_h = 0, m_v = 0, m_fs = 0;
   bit m_en = 0, m_pwr = 0;
   bit [2:0] m_pol = '0;
   bit [31:0] p_hw = '0, p_vw = '0, a_hw = '0, a_vw = '0;
   int fs_seen = 0, x_wraps = 0, prev_x = 0, max_x = 0;

   function automatic int h_act(bit [31:0] w); return (((w >> 2) & 63) + 1) * 16; endfunction
   function automatic int h_s0(bit [31:0] w); return h_act(w) + ((w >> 16) & 255) + 1; endfunction
   function automatic int h_s1(bit [31:0] w); return h_s0(w) + ((w >> 8) & 255) + 1; endfunction
   function automatic int h_len(bit [31:0] w); return h_s1(w) + ((w >> 24) & 255) + 1; endfunction
   function automatic int v_act(bit [31:0] w); return (w & 1023) + 1; endfunction
   function automatic int v_s0(bit [31:0] w); return v_act(w) + ((w >> 16) & 255); endfunction
   function automatic int v_s1(bit [31:0] w); return v_s0(w) + ((w >> 10) & 63) + 1; endfunction
   function automatic int v_len(bit [31:0] w); return v_s1(w) + ((w >> 24) & 255); endfunction

   function automatic bit [31:0] mk_h(int ppl, int hsw, int hfp, int hbp);
      return (32'(ppl) << 2) | (32'(hsw) << 8) | (32'(hfp) << 16) | (32'(hbp) << 24);
   endfunction
   function automatic bit [31:0] mk_v(int lpp, int vsw, int vfp, int vbp);
      return 32'(lpp) | (32'(vsw) << 10) | (32'(vfp) << 16) | (32'(vbp) << 24);
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic compare();
      int de_e, hs_e, vs_e;
      de_e = (m_en && m_h < h_act(a_hw) && m_v < v_act(a_vw)) ? 1 : 0;
      hs_e = ((m_en && m_h >= h_s0(a_hw) && m_h < h_s1(a_hw)) ? 1 : 0) ^ int'(m_pol[1]);
      vs_e = ((m_en && m_v >= v_s0(a_vw) && m_v < v_s1(a_vw)) ? 1 : 0) ^ int'(m_pol[0]);
      chk("R10 pix_x", int'(pix_x_o), m_h);
      chk("R10 pix_y", int'(pix_y_o), m_v);
      chk("R4 de", int'(de_o), de_e);
      chk("R2 hsync", int'(hsync_o), hs_e);
      chk("R3 vsync", int'(vsync_o), vs_e);
      chk("R9 frame_start", int'(frame_start_o), m_fs);
      chk("R7 panel power", int'(panel_pwr_o), int'(m_pwr));
      chk("R6 pclk", int'(pclk_o), int'(pclk_i ^ m_pol[2]));
      if (frame_start_o) fs_seen++;
      if (int'(pix_x_o) == 0 && prev_x != 0) x_wraps++;
      if (int'(pix_x_o) > max_x) max_x = int'(pix_x_o);
      prev_x = int'(pix_x_o);
   endtask

   task automatic cyc(bit ce, bit we = 1'b0, bit [1:0] ad = 2'd0, bit [31:0] d = '0);
      pix_ce  = ce;
      wr_en   = we;
      wr_addr = ad;
      wr_data = d;
      pclk_i  = ~pclk_i;
      @(posedge clk);
      if (!m_en) begin
         m_h = 0; m_v = 0; m_fs = 0; a_hw = p_hw; a_vw = p_vw;
      end else begin
         m_fs = 0;
         if (ce) begin
            if (m_h == h_len(a_hw) - 1) begin
               m_h = 0;
               if (m_v == v_s0(a_vw) - 1) m_fs = 1;
               if (m_v == v_len(a_vw) - 1) begin
                  m_v = 0; a_hw = p_hw; a_vw = p_vw;
               end else m_v++;
            end else m_h++;
         end
      end
      if (we) begin
         case (ad)
            2'd0: p_hw = d;
            2'd1: p_vw = d;
            2'd2: m_pol = d[2:0];
            default: begin m_en = d[0]; m_pwr = d[1]; end
         endcase
      end
      @(negedge clk);
      compare();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R7: idle state out of reset
      chk("R7 reset x", int'(pix_x_o), 0);
      chk("R7 reset de", int'(de_o), 0);
      chk("R7 reset hsync", int'(hsync_o), 0);
      chk("R7 reset vsync", int'(vsync_o), 0);
      chk("R7 reset power", int'(panel_pwr_o), 0);
      cyc(0);

      // Scenario A: 22-pixel lines, 8-line frames, continuous enable
      cyc(0, 1, 2'd0, mk_h(0, 0, 1, 2));
      cyc(0, 1, 2'd1, mk_v(3, 1, 1, 1));
      cyc(0, 1, 2'd3, 32'h3);
      fs_seen = 0; x_wraps = 0;
      repeat (352) cyc(1);
      chk("R1 line wraps in 352 pixels", x_wraps, 352 / h_len(mk_h(0, 0, 1, 2)));
      chk("R3 frames in 352 pixels", fs_seen, 352 / (22 * v_len(mk_v(3, 1, 1, 1))));

      // Scenario B: disable, inverted polarity, zero vertical porches, sparse enable
      cyc(0, 1, 2'd3, 32'h0);
      cyc(0);
      chk("R7 idle x", int'(pix_x_o), 0);
      chk("R7 idle y", int'(pix_y_o), 0);
      cyc(0, 1, 2'd2, 32'h7);
      chk("R6 hsync inverted idle", int'(hsync_o), 1);
      chk("R6 vsync inverted idle", int'(vsync_o), 1);
      cyc(0, 1, 2'd0, mk_h(1, 2, 0, 0));
      cyc(0, 1, 2'd1, mk_v(2, 0, 0, 0));
      cyc(0, 1, 2'd3, 32'h1);
      chk("R7 power independent of enable", int'(panel_pwr_o), 0);
      for (int i = 0; i < 300; i++) begin
         int xb;
         xb = int'(pix_x_o);
         cyc(bit'(i % 2));
         if (i % 2 == 0 && i < 40) chk("R5 hold without pixel enable", int'(pix_x_o), xb);
      end

      // R8: mid-frame horizontal rewrite keeps old length until frame end
      while (int'(pix_y_o) != 1) cyc(1);
      cyc(1, 1, 2'd0, mk_h(0, 0, 1, 2));
      max_x = 0;
      while (int'(pix_y_o) != 0) cyc(1);
      chk("R8 old line length kept", max_x, h_len(mk_h(1, 2, 0, 0)) - 1);
      max_x = 0;
      repeat (60) cyc(1);
      chk("R8 new line length applied", max_x, h_len(mk_h(0, 0, 1, 2)) - 1);

      // Sweep of porch and sync settings, normal polarity
      cyc(0, 1, 2'd2, 32'h0);
      for (int hfp = 0; hfp < 3; hfp++)
         for (int hsw = 0; hsw < 3; hsw++)
            for (int vfp = 0; vfp < 2; vfp++)
               for (int vbp = 0; vbp < 2; vbp++)
                  for (int vsw = 0; vsw < 2; vsw++) begin
                     cyc(0, 1, 2'd3, 32'h0);
                     cyc(0, 1, 2'd0, mk_h(0, hsw, hfp, 1));
                     cyc(0, 1, 2'd1, mk_v(1, vsw, vfp, vbp));
                     cyc(0, 1, 2'd3, 32'h3);
                     fs_seen = 0;
                     repeat (h_len(mk_h(0, hsw, hfp, 1)) * v_len(mk_v(1, vsw, vfp, vbp)) + 3) cyc(1);
                     chk("R9 one frame-start per frame", fs_seen, 1);
                  end

      // R7: power on while timing disabled
      cyc(1, 1, 2'd3, 32'h2);
      cyc(1);
      chk("R7 power with timing off", int'(panel_pwr_o), 1);
      chk("R7 de off when disabled", int'(de_o), 0);
      cyc(0);
      summary();
      $finish;
   end

endmodule